// File: doc/BRIEF.md
# Write-Tracking Checksum Guard for a Data RAM

This block sits between a single requester and a small single-port data RAM and keeps a 32-bit wrapping sum of every word in the RAM. Each write passes through the block. The block first reads the word about to be replaced. In the next cycle it stores the new word and adjusts the sum by the difference between the new and old values, so the whole region never has to be added up again to keep the sum current. Reads pass straight through with one cycle of latency.

A background walker runs alongside. It re-adds every word of the region at a pace set by software and compares its total with the maintained sum. Writes that land on words the walker has already counted also correct the walker's partial total, so a pass that overlaps normal traffic still gives a valid verdict. If the two totals differ, the block latches an error, records the pass number and both sums, raises a halt request for an external watchdog, and refuses further requests until software clears the error. After reset the block fills the RAM with zeros, so the sum starts from a known value.

Top module: `csum_guard`

## Requirements
- R1: After reset the block writes the value 0 to every RAM word in ascending address order, one word per cycle starting in the first cycle after reset. During this fill `req_ready` stays low. Afterwards `csum` reads 0.
- R2: A write request (`req_we`=1) takes two cycles. In the first cycle `req_ready` is low and the RAM is read at the target address. In the second cycle `req_ready` is high and the new data is written at that address.
- R3: In the cycle after a write is stored, `csum` equals the previous `csum` minus the old word plus the new word, modulo 2^32.
- R4: A read request (`req_we`=0) is accepted in the cycle it is presented while the block is idle. `rsp_valid` is high in the next cycle, and `rsp_rdata` then holds the stored word.
- R5: The walker issues RAM reads only in cycles when the requester port does not use the RAM. Two walker reads are at least `scan_period`+1 cycles apart. The RAM never sees a read and a write in the same cycle.
- R6: When the RAM holds exactly what was written through the block, a completed pass never raises an error. This holds even when writes and reads are interleaved with the pass.
- R7: When a completed pass finds a total different from `csum`, `err_flag` and `halt_req` go high in the next cycle. At that point `err_expected` holds the maintained sum, `err_found` holds the walker's total, and `err_pass` holds the number of the failing pass (`pass_count` minus one).
- R8: `err_flag` and the captured values stay set until `err_clear` is asserted. While `err_flag` is high, `req_ready` stays low and no further passes complete.
- R9: `pass_count` increments by one at the end of each completed pass.
- R10: While `scan_en` is low, the walker issues no RAM reads and `pass_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mem_re | output | 1 | RAM read enable (data returns next cycle) |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data |
| scan_en | input | 1 | Enables the background walker |
| scan_period | input | PW | Minimum idle cycles between walker reads |
| err_clear | input | 1 | Clears the latched error |
| csum | output | 32 | Maintained checksum |
| pass_count | output | CW | Number of completed walker passes |
| err_flag | output | 1 | Sticky mismatch flag |
| halt_req | output | 1 | Halt request to the watchdog |
| err_pass | output | CW | Pass number of the mismatch |
| err_expected | output | 32 | Maintained sum at the mismatch |
| err_found | output | 32 | Walker total at the mismatch |

## Verification
The bench mixes writes and reads, some with wrapping values, while the walker runs. This targets a walker that forgets to credit writes to words it has already counted; such a design would report false mismatches. It measures how far apart walker reads are and checks that port cycles take priority, which catches a walker that steals port cycles or ignores its pace. It flips a bit in the RAM behind the block's back and expects an error carrying the exact predicted sums and pass number. It then checks that the error holds and the port stays locked until cleared, which catches a flag that clears itself or a block that keeps serving requests while halted.

// File: rtl/csg_pkg.sv
package csg_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PS_FILL   = 2'd0,
        PS_IDLE   = 2'd1,
        PS_COMMIT = 2'd2
    } port_state_e;

    typedef struct packed {
        logic  re;
        logic  we;
        word_t wdata;
    } mem_cmd_t;

    function automatic word_t csum_step(word_t sum, word_t old_w, word_t new_w);
        return sum - old_w + new_w;
    endfunction
endpackage

// File: rtl/csg_port_ctl.sv
module csg_port_ctl
    import csg_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  word_t         req_wdata,
    input  logic          halt,
    input  word_t         mem_rdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic          port_busy,
    output mem_cmd_t      cmd,
    output logic [AW-1:0] cmd_addr,
    output word_t         sum,
    output logic          adj_valid,
    output logic [AW-1:0] adj_addr,
    output word_t         adj_delta,
    output logic          fill_done
);
    port_state_e   state;
    logic [AW-1:0] fill_ptr;
    logic [AW-1:0] wr_addr_q;
    word_t         wr_data_q;
    logic          take_rd, take_wr;

    assign take_rd = (state == PS_IDLE) && !halt && req_valid && !req_we;
    assign take_wr = (state == PS_IDLE) && !halt && req_valid && req_we;

    always_comb begin
        cmd       = '0;
        cmd_addr  = req_addr;
        req_ready = 1'b0;
        port_busy = 1'b0;
        adj_valid = 1'b0;
        adj_delta = wr_data_q - mem_rdata;
        case (state)
            PS_FILL: begin
                cmd.we    = 1'b1;
                cmd_addr  = fill_ptr;
                port_busy = 1'b1;
            end
            PS_IDLE: begin
                req_ready = !halt && !req_we;
                if (take_rd || take_wr) begin
                    cmd.re    = 1'b1;
                    port_busy = 1'b1;
                end
            end
            PS_COMMIT: begin
                cmd.we    = 1'b1;
                cmd.wdata = wr_data_q;
                cmd_addr  = wr_addr_q;
                req_ready = 1'b1;
                port_busy = 1'b1;
                adj_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign adj_addr  = wr_addr_q;
    assign fill_done = (state != PS_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_FILL;
            fill_ptr  <= '0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            sum       <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= take_rd;
            case (state)
                PS_FILL: begin
                    fill_ptr <= fill_ptr + 1'b1;
                    if (&fill_ptr) state <= PS_IDLE;
                end
                PS_IDLE: begin
                    if (take_wr) begin
                        wr_addr_q <= req_addr;
                        wr_data_q <= req_wdata;
                        state     <= PS_COMMIT;
                    end
                end
                PS_COMMIT: begin
                    sum   <= csum_step(sum, mem_rdata, wr_data_q);
                    state <= PS_IDLE;
                end
                default: state <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/csg_walker.sv
module csg_walker
    import csg_pkg::*;
#(
    parameter int AW = 4,
    parameter int PW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [PW-1:0] period,
    input  logic          port_busy,
    input  word_t         mem_rdata,
    input  logic          adj_valid,
    input  logic [AW-1:0] adj_addr,
    input  word_t         adj_delta,
    output logic          wk_re,
    output logic [AW-1:0] wk_addr,
    output logic          pass_done,
    output word_t         partial,
    output logic [CW-1:0] pass_cnt
);
    logic          active, pend;
    logic [AW:0]   rd_ptr;
    logic [PW-1:0] step_cnt;
    word_t         nxt;

    assign wk_addr = rd_ptr[AW-1:0];

    always_comb begin
        wk_re     = go && active && !rd_ptr[AW] && !port_busy && (step_cnt >= period);
        pass_done = active && rd_ptr[AW] && !pend;
        nxt       = partial;
        if (pend) nxt = nxt + mem_rdata;
        if (adj_valid && ({1'b0, adj_addr} < rd_ptr)) nxt = nxt + adj_delta;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            pend     <= 1'b0;
            rd_ptr   <= '0;
            step_cnt <= '0;
            partial  <= '0;
            pass_cnt <= '0;
        end else begin
            pend    <= wk_re;
            partial <= nxt;
            if (wk_re) rd_ptr <= rd_ptr + 1'b1;
            if (wk_re) step_cnt <= '0;
            else if (go && step_cnt < period) step_cnt <= step_cnt + 1'b1;
            if (pass_done) begin
                active   <= 1'b0;
                pass_cnt <= pass_cnt + 1'b1;
            end else if (!active && go) begin
                active  <= 1'b1;
                rd_ptr  <= '0;
                partial <= '0;
            end
        end
    end
endmodule

// File: rtl/csg_err_cap.sv
module csg_err_cap
    import csg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pass_done,
    input  word_t         partial,
    input  word_t         sum,
    input  logic [CW-1:0] pass_cnt,
    input  logic          clear,
    output logic          err_flag,
    output logic [CW-1:0] err_pass,
    output word_t         err_expected,
    output word_t         err_found
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag     <= 1'b0;
            err_pass     <= '0;
            err_expected <= '0;
            err_found    <= '0;
        end else if (pass_done && (partial != sum)) begin
            err_flag     <= 1'b1;
            err_pass     <= pass_cnt;
            err_expected <= sum;
            err_found    <= partial;
        end else if (clear) begin
            err_flag     <= 1'b0;
            err_pass     <= '0;
            err_expected <= '0;
            err_found    <= '0;
        end
    end
endmodule

// File: rtl/csum_guard.sv
module csum_guard
    import csg_pkg::*;
#(
    parameter int AW = 4,
    parameter int PW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          scan_en,
    input  logic [PW-1:0] scan_period,
    input  logic          err_clear,
    output logic [31:0]   csum,
    output logic [CW-1:0] pass_count,
    output logic          err_flag,
    output logic          halt_req,
    output logic [CW-1:0] err_pass,
    output logic [31:0]   err_expected,
    output logic [31:0]   err_found
);
    mem_cmd_t      pcmd;
    logic [AW-1:0] paddr, wk_addr, adj_addr;
    logic          port_busy, adj_valid, fill_done, wk_re, pass_done, go;
    word_t         adj_delta, partial;

    assign go = scan_en && !err_flag && fill_done;

    csg_port_ctl #(.AW(AW)) u_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .halt(err_flag),
        .mem_rdata(mem_rdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .port_busy(port_busy), .cmd(pcmd), .cmd_addr(paddr), .sum(csum),
        .adj_valid(adj_valid), .adj_addr(adj_addr), .adj_delta(adj_delta),
        .fill_done(fill_done)
    );

    csg_walker #(.AW(AW), .PW(PW), .CW(CW)) u_walk (
        .clk(clk), .rst(rst), .go(go), .period(scan_period), .port_busy(port_busy),
        .mem_rdata(mem_rdata), .adj_valid(adj_valid), .adj_addr(adj_addr),
        .adj_delta(adj_delta), .wk_re(wk_re), .wk_addr(wk_addr),
        .pass_done(pass_done), .partial(partial), .pass_cnt(pass_count)
    );

    csg_err_cap #(.CW(CW)) u_err (
        .clk(clk), .rst(rst), .pass_done(pass_done), .partial(partial), .sum(csum),
        .pass_cnt(pass_count), .clear(err_clear), .err_flag(err_flag),
        .err_pass(err_pass), .err_expected(err_expected), .err_found(err_found)
    );

    assign mem_re    = pcmd.re || wk_re;
    assign mem_we    = pcmd.we;
    assign mem_addr  = port_busy ? paddr : wk_addr;
    assign mem_wdata = pcmd.wdata;
    assign rsp_rdata = mem_rdata;
    assign halt_req  = err_flag;
endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_we,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_re,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic [31:0]   mem_rdata,
    input logic [31:0]   csum,
    input logic          err_flag,
    input logic          err_clear,
    input logic          fill_done,
    input logic          pass_done
);
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_we && fill_done) |-> ($past(mem_re) && $past(mem_addr) == mem_addr)); // R2
    AST_SUM_DELTA: assert property (@(posedge clk) disable iff (rst)
        (mem_we && fill_done) |=> (csum == $past(csum) - $past(mem_rdata) + $past(mem_wdata))); // R3
    AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_we && req_ready)); // R4
    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R5
    AST_ERR_AFTER_PASS: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(pass_done)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(err_flag) && !$past(err_clear)) |-> err_flag); // R8
    AST_NO_ACCEPT_HALTED: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !mem_we) |-> !req_ready); // R8
endmodule

bind csum_guard csg_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .csum(csum), .err_flag(err_flag),
    .err_clear(err_clear), .fill_done(fill_done), .pass_done(pass_done)
);

// File: tb/sim_csum_guard.sv
module sim_csum_guard;
    localparam int AW = 4;
    localparam int PW = 8;
    localparam int CW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          scan_en = 1'b0;
    logic [PW-1:0] scan_period = 8'd2;
    logic          err_clear = 1'b0;
    logic [31:0]   csum;
    logic [CW-1:0] pass_count, err_pass;
    logic          err_flag, halt_req;
    logic [31:0]   err_expected, err_found;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] bram [DEPTH];
    logic [31:0] shadow [DEPTH];
    logic [31:0] model_sum = '0;
    logic [31:0] rd_q[$];
    logic          corrupt_go = 1'b0;
    logic [AW-1:0] corrupt_addr = '0;
    int last_wk = -1000;
    int min_gap = 1000000;
    int wk_reads = 0;

    always #10 clk = ~clk;

    csum_guard #(.AW(AW), .PW(PW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .scan_en(scan_en), .scan_period(scan_period),
        .err_clear(err_clear), .csum(csum), .pass_count(pass_count),
        .err_flag(err_flag), .halt_req(halt_req), .err_pass(err_pass),
        .err_expected(err_expected), .err_found(err_found)
    );

    // RAM model behind the block
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) bram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= bram[mem_addr];
        if (corrupt_go) bram[corrupt_addr] <= bram[corrupt_addr] ^ 32'h1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: read scoreboard and walker spacing
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (rd_q.size() == 0) chk(1'b0, "R4 unexpected rsp", rsp_rdata, 32'h0);
            else begin
                logic [31:0] e;
                e = rd_q.pop_front();
                chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
            end
        end
        if (!rst && mem_re && !req_valid) begin
            wk_reads++;
            if (cyc - last_wk < min_gap) min_gap = cyc - last_wk;
            last_wk = cyc;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        int n = 0;
        bit rdy;
        req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
        do begin #1; rdy = req_ready; n++; @(negedge clk); end while (!rdy && n < 50);
        req_valid = 0; req_we = 0;
        chk(n == 2, "R2 write cycles", n, 2);
        model_sum = model_sum - shadow[a] + d;
        shadow[a] = d;
        chk(csum == model_sum, "R3 sum after write", csum, model_sum);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        int n = 0;
        bit rdy;
        req_valid = 1; req_we = 0; req_addr = a;
        do begin
            #1; rdy = req_ready; n++;
            if (rdy) rd_q.push_back(shadow[a]);
            @(negedge clk);
        end while (!rdy && n < 50);
        req_valid = 0;
        chk(n == 1, "R4 read cycles", n, 1);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin bram[i] = 32'hDEAD0000 + i; shadow[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < DEPTH; i++) begin
            #1;
            chk(mem_we && mem_wdata == 0 && mem_addr == i[AW-1:0], "R1 fill write", {mem_we, mem_addr}, i);
            chk(!req_ready, "R1 ready low in fill", req_ready, 0);
            @(negedge clk);
        end
        chk(csum == 0, "R1 sum after fill", csum, 0);
        chk(!err_flag && !halt_req, "R7 no error at reset", err_flag, 0);

        // directed writes with wrap
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        wr(0, 32'h0000_0005);
        wr(DEPTH-1, 32'h8000_0000);
        rd(0); rd(1); rd(DEPTH-1);
        repeat (2) @(negedge clk);

        // walker with mixed traffic
        begin
            logic [CW-1:0] pc0;
            logic [31:0] lcg = 32'h1234_5678;
            scan_en = 1;
            pc0 = pass_count;
            for (int k = 0; k < 150; k++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                if (lcg[3]) wr(lcg[AW+7:8], lcg ^ 32'hA5A5_0000);
                else if (lcg[4]) rd(lcg[AW+11:12]);
                else repeat (lcg[6:5]) @(negedge clk);
            end
            repeat (200) @(negedge clk);
            chk(!err_flag, "R6 no false error", err_flag, 0);
            chk(pass_count - pc0 >= 3, "R9 passes advance", pass_count - pc0, 3);
            chk(min_gap >= int'(scan_period) + 1, "R5 walker spacing", min_gap, scan_period + 1);
            chk(wk_reads > 0, "R5 walker active", wk_reads, 1);
        end

        // pass counter steps by one
        begin
            logic [CW-1:0] p;
            p = pass_count;
            while (pass_count == p) @(negedge clk);
            chk(pass_count == p + 1, "R9 single step", pass_count, p + 1);
        end

        // corruption behind the block
        begin
            logic [31:0] exp_found;
            logic [CW-1:0] pc;
            int w = 0;
            corrupt_addr = 3; corrupt_go = 1; @(negedge clk); corrupt_go = 0;
            exp_found = model_sum - shadow[3] + (shadow[3] ^ 32'h1);
            while (!err_flag && w < 2000) begin @(negedge clk); w++; end
            chk(err_flag && halt_req, "R7 error raised", {err_flag, halt_req}, 3);
            chk(err_expected == model_sum, "R7 expected sum", err_expected, model_sum);
            chk(err_found == exp_found, "R7 found sum", err_found, exp_found);
            chk(err_pass == pass_count - 1, "R7 pass number", err_pass, pass_count - 1);
            pc = pass_count;
            req_valid = 1; req_we = 0; req_addr = 2;
            for (int k = 0; k < 40; k++) begin
                #1; chk(!req_ready, "R8 port locked", req_ready, 0);
                @(negedge clk);
            end
            req_valid = 0;
            chk(err_flag, "R8 flag sticky", err_flag, 1);
            chk(pass_count == pc, "R8 walker stopped", pass_count, pc);
            chk(err_found == exp_found, "R8 capture held", err_found, exp_found);
            corrupt_go = 1; @(negedge clk); corrupt_go = 0;
            err_clear = 1; @(negedge clk); err_clear = 0;
            chk(!err_flag && !halt_req, "R8 cleared", err_flag, 0);
            repeat (250) @(negedge clk);
            chk(!err_flag, "R6 clean after repair", err_flag, 0);
            rd(2);
        end

        // walker disabled
        begin
            logic [CW-1:0] pc;
            int r0;
            scan_en = 0;
            repeat (3) @(negedge clk);
            pc = pass_count; r0 = wk_reads;
            repeat (150) @(negedge clk);
            chk(wk_reads == r0, "R10 no walker reads", wk_reads - r0, 0);
            chk(pass_count == pc, "R10 pass count frozen", pass_count, pc);
        end

        repeat (3) @(negedge clk);
        chk(rd_q.size() == 0, "R4 all reads answered", rd_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule